// File: doc/BRIEF.md
# L2-to-L1 Reply Router

The router sits at the output of an L2 cache and takes one completed fill reply at a time from an L2 reply source. Each reply comes with four attribute flags: it was produced by the L2 prefetcher, it belongs to an access that already hit for a write in L1, it has an L1 miss-status entry waiting for it, and it came from an instruction fetch. From these flags the router chooses exactly one outcome:

- release the reply (prefetcher-generated or L1 write hit),
- finish the access at L2 with a global-perform pulse (no waiting L1 entry),
- push the reply into the instruction L1 reply queue, or
- push the reply into the data L1 reply queue.

The router holds a reply back only when the queue it needs is full. The reply then stays at the input, with the ready signal low, until that queue has room. The outcome appears as a one-cycle pulse in the cycle after acceptance. A registered copy of the reply's tag and progress field comes out with it. For a reply pushed into an L1 queue, the progress field is cleared to zero.

Top module: `l2l1_reply_router`

## Requirements
- R1: After a synchronous active-low reset, iq_push, dq_push, gperf_pulse and release_pulse are all low, and fwd_tag and fwd_prog are zero.
- R2: An accepted reply with rsp_pref=1 yields release_pulse in the next cycle, whatever its other flags are, and never touches either L1 queue.
- R3: An accepted reply with rsp_pref=0 and rsp_l1wh=1 yields release_pulse in the next cycle, whatever rsp_has_mshr and rsp_ifetch are.
- R4: An accepted reply with rsp_pref=0, rsp_l1wh=0 and rsp_has_mshr=0 yields gperf_pulse in the next cycle and is not forwarded.
- R5: An accepted reply with rsp_pref=0, rsp_l1wh=0, rsp_has_mshr=1 and rsp_ifetch=1 yields iq_push in the next cycle.
- R6: An accepted reply with rsp_pref=0, rsp_l1wh=0, rsp_has_mshr=1 and rsp_ifetch=0 yields dq_push in the next cycle.
- R7: rsp_rdy is low exactly when rsp_vld is high and the reply is routed to a queue whose full flag is set. Replies that are released or globally performed are accepted even when both queues are full.
- R8: A reply that is not accepted (rsp_vld=1, rsp_rdy=0) produces no pulse in the next cycle. Once the queue frees, the held reply is delivered once.
- R9: In the cycle of a pulse, fwd_tag equals the accepted reply's tag. fwd_prog is zero for a queue push and equals the input progress for other outcomes.
- R10: At most one of the four outcome outputs is high in any cycle.
- R11: A cycle with rsp_vld low produces no pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rsp_vld | input | 1 | A reply is offered |
| rsp_pref | input | 1 | Reply was produced by the L2 prefetcher |
| rsp_l1wh | input | 1 | Reply belongs to an L1 write hit |
| rsp_has_mshr | input | 1 | An L1 miss-status entry awaits this reply |
| rsp_ifetch | input | 1 | Reply is for an instruction fetch |
| rsp_tag | input | TAG_W | Reply identifier |
| rsp_prog | input | PROG_W | Reply progress field |
| iq_full | input | 1 | Instruction L1 reply queue is full |
| dq_full | input | 1 | Data L1 reply queue is full |
| rsp_rdy | output | 1 | Reply accepted this cycle when high with rsp_vld |
| iq_push | output | 1 | Enqueue strobe, instruction L1 reply queue |
| dq_push | output | 1 | Enqueue strobe, data L1 reply queue |
| fwd_tag | output | TAG_W | Tag of the reply behind the current pulse |
| fwd_prog | output | PROG_W | Progress of that reply (zero when forwarded) |
| gperf_pulse | output | 1 | Global-perform completion at L2 |
| release_pulse | output | 1 | Reply released without L1 action |

## Verification
A queue-full condition can coincide with a reply that does not need a queue, and in that case stalling would be wrong. The bench raises both full flags while it offers prefetcher, write-hit and no-entry replies. It expects rsp_rdy to stay high and the proper single pulse to follow. It also holds an instruction reply against a full instruction queue while the data queue is free. It then confirms that rsp_rdy stays low, that no pulse leaks out, and that exactly one iq_push follows once the full flag drops.

// File: rtl/rr_pkg.sv
// Package: shared types of the L2-to-L1 reply router.
package rr_pkg;
    // Outcome chosen for the reply at the input.
    typedef enum logic [2:0] {
        RT_NONE    = 3'd0,
        RT_RELEASE = 3'd1,
        RT_GPERF   = 3'd2,
        RT_IQ      = 3'd3,
        RT_DQ      = 3'd4
    } route_e;
endpackage

// File: rtl/rr_classify.sv
// Module: rr_classify
// Picks the outcome of the offered reply by a fixed priority: prefetch,
// then L1 write hit, then missing L1 entry, then fetch type. It also
// derives ready. Assumes that flags are only meaningful while vld is high.
module rr_classify
    import rr_pkg::*;
(
    input  logic   vld,
    input  logic   pref,
    input  logic   l1wh,
    input  logic   has_mshr,
    input  logic   ifetch,
    input  logic   iq_full,
    input  logic   dq_full,
    output route_e route,
    output logic   rdy
);
    logic blocked;

    // Priority classification of the offered reply.
    always_comb begin
        route = RT_NONE;
        if (vld) begin
            if (pref)
                route = RT_RELEASE;
            else if (l1wh)
                route = RT_RELEASE;
            else if (!has_mshr)
                route = RT_GPERF;
            else if (ifetch)
                route = RT_IQ;
            else
                route = RT_DQ;
        end
    end

    // Back-pressure only when the needed queue is full.
    always_comb begin
        blocked = ((route == RT_IQ) && iq_full) || ((route == RT_DQ) && dq_full);
        rdy     = !blocked;
    end
endmodule

// File: rtl/rr_outreg.sv
// Module: rr_outreg
// Turns an accepted outcome into a one-cycle registered pulse and captures
// the reply payload. The progress field is cleared for queue pushes.
// Assumes accept is high only when route is not RT_NONE.
module rr_outreg
    import rr_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int PROG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  route_e            route,
    input  logic [TAG_W-1:0]  tag,
    input  logic [PROG_W-1:0] prog,
    output logic              iq_push,
    output logic              dq_push,
    output logic              gperf,
    output logic              release_p,
    output logic [TAG_W-1:0]  tag_q,
    output logic [PROG_W-1:0] prog_q
);
    localparam logic [PROG_W-1:0] PROG_CLR = '0;

    logic fwd;

    // Marks outcomes that enter an L1 queue.
    always_comb fwd = (route == RT_IQ) || (route == RT_DQ);

    // Outcome pulses: one cycle, only after an acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iq_push   <= 1'b0;
            dq_push   <= 1'b0;
            gperf     <= 1'b0;
            release_p <= 1'b0;
        end else begin
            iq_push   <= accept && (route == RT_IQ);
            dq_push   <= accept && (route == RT_DQ);
            gperf     <= accept && (route == RT_GPERF);
            release_p <= accept && (route == RT_RELEASE);
        end
    end

    // Payload capture on acceptance; progress restarts for forwarded replies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            prog_q <= '0;
        end else if (accept) begin
            tag_q  <= tag;
            prog_q <= fwd ? PROG_CLR : prog;
        end
    end
endmodule

// File: rtl/l2l1_reply_router.sv
// Module: l2l1_reply_router (top)
// Routes completed L2 replies to release, global perform, or one of two
// L1 reply queues. Assumes that the source keeps a reply and its flags
// stable while rsp_vld is high and rsp_rdy is low.
module l2l1_reply_router
    import rr_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int PROG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_vld,
    input  logic              rsp_pref,
    input  logic              rsp_l1wh,
    input  logic              rsp_has_mshr,
    input  logic              rsp_ifetch,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [PROG_W-1:0] rsp_prog,
    input  logic              iq_full,
    input  logic              dq_full,
    output logic              rsp_rdy,
    output logic              iq_push,
    output logic              dq_push,
    output logic [TAG_W-1:0]  fwd_tag,
    output logic [PROG_W-1:0] fwd_prog,
    output logic              gperf_pulse,
    output logic              release_pulse
);
    route_e route;
    logic   accept;

    rr_classify u_cls (
        .vld      (rsp_vld),
        .pref     (rsp_pref),
        .l1wh     (rsp_l1wh),
        .has_mshr (rsp_has_mshr),
        .ifetch   (rsp_ifetch),
        .iq_full  (iq_full),
        .dq_full  (dq_full),
        .route    (route),
        .rdy      (rsp_rdy)
    );

    // Handshake: the reply is taken when offered and not blocked.
    always_comb accept = rsp_vld && rsp_rdy;

    rr_outreg #(.TAG_W(TAG_W), .PROG_W(PROG_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .route     (route),
        .tag       (rsp_tag),
        .prog      (rsp_prog),
        .iq_push   (iq_push),
        .dq_push   (dq_push),
        .gperf     (gperf_pulse),
        .release_p (release_pulse),
        .tag_q     (fwd_tag),
        .prog_q    (fwd_prog)
    );
endmodule

// File: rtl/rr_checker.sv
// Module: rr_checker
// Temporal checks on the router's ports, bound into every instance.
module rr_checker #(
    parameter int TAG_W  = 8,
    parameter int PROG_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_vld,
    input logic              rsp_pref,
    input logic              rsp_l1wh,
    input logic              rsp_has_mshr,
    input logic              rsp_ifetch,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic              iq_full,
    input logic              dq_full,
    input logic              rsp_rdy,
    input logic              iq_push,
    input logic              dq_push,
    input logic [TAG_W-1:0]  fwd_tag,
    input logic              gperf_pulse,
    input logic              release_pulse
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iq_push, dq_push, gperf_pulse, release_pulse})); // R10
    AST_PREF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_rdy && rsp_pref) |=> release_pulse); // R2
    AST_NOMSHR_GPERF: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_rdy && !rsp_pref && !rsp_l1wh && !rsp_has_mshr) |=> gperf_pulse); // R4
    AST_IQ_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_pref && !rsp_l1wh && rsp_has_mshr && rsp_ifetch && iq_full) |-> !rsp_rdy); // R7
    AST_DQ_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_pref && !rsp_l1wh && rsp_has_mshr && !rsp_ifetch && dq_full) |-> !rsp_rdy); // R7
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_rdy) |=> !(iq_push || dq_push || gperf_pulse || release_pulse)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |=> !(iq_push || dq_push || gperf_pulse || release_pulse)); // R11
    AST_FWD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_rdy) |=> (fwd_tag == $past(rsp_tag))); // R9
endmodule

bind l2l1_reply_router rr_checker #(.TAG_W(TAG_W), .PROG_W(PROG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rsp_vld       (rsp_vld),
    .rsp_pref      (rsp_pref),
    .rsp_l1wh      (rsp_l1wh),
    .rsp_has_mshr  (rsp_has_mshr),
    .rsp_ifetch    (rsp_ifetch),
    .rsp_tag       (rsp_tag),
    .iq_full       (iq_full),
    .dq_full       (dq_full),
    .rsp_rdy       (rsp_rdy),
    .iq_push       (iq_push),
    .dq_push       (dq_push),
    .fwd_tag       (fwd_tag),
    .gperf_pulse   (gperf_pulse),
    .release_pulse (release_pulse)
);

// File: tb/sim_l2l1_reply_router.sv
module sim_l2l1_reply_router;
    localparam int TW = 8;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rsp_vld = 1'b0, rsp_pref = 1'b0, rsp_l1wh = 1'b0;
    logic          rsp_has_mshr = 1'b0, rsp_ifetch = 1'b0;
    logic [TW-1:0] rsp_tag = '0;
    logic [PW-1:0] rsp_prog = '0;
    logic          iq_full = 1'b0, dq_full = 1'b0;
    logic          rsp_rdy, iq_push, dq_push, gperf_pulse, release_pulse;
    logic [TW-1:0] fwd_tag;
    logic [PW-1:0] fwd_prog;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    l2l1_reply_router #(.TAG_W(TW), .PROG_W(PW)) u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Outcome code: 0 none, 1 iq, 2 dq, 3 gperf, 4 release, 9 several.
    function automatic int outcome();
        int c;
        c = int'(iq_push) + int'(dq_push) + int'(gperf_pulse) + int'(release_pulse);
        if (c == 0) return 0;
        if (c > 1) return 9;
        if (iq_push) return 1;
        if (dq_push) return 2;
        if (gperf_pulse) return 3;
        return 4;
    endfunction

    // Offer one reply at a negedge, check ready, then check the pulse one cycle later.
    task automatic offer(input bit p, input bit w, input bit m, input bit f,
                         input logic [TW-1:0] t, input logic [PW-1:0] g,
                         input int exp_out, input string req);
        rsp_vld = 1'b1; rsp_pref = p; rsp_l1wh = w; rsp_has_mshr = m; rsp_ifetch = f;
        rsp_tag = t; rsp_prog = g;
        #1;
        check(rsp_rdy === 1'b1, {req, " ready"}, int'(rsp_rdy), 1);
        @(negedge clk);
        rsp_vld = 1'b0;
        check(outcome() == exp_out, {req, " outcome"}, outcome(), exp_out);
        check(fwd_tag == t, {req, " R9 tag"}, int'(fwd_tag), int'(t));
        check(fwd_prog == ((exp_out == 1 || exp_out == 2) ? '0 : g),
              {req, " R9 prog"}, int'(fwd_prog),
              (exp_out == 1 || exp_out == 2) ? 0 : int'(g));
    endtask

    task automatic t_reset();
        check(outcome() == 0, "R1 pulses", outcome(), 0);
        check(fwd_tag == 0 && fwd_prog == 0, "R1 payload", int'(fwd_tag), 0);
    endtask

    task automatic t_classes();
        offer(1, 1, 1, 1, 8'h11, 4'h3, 4, "R2 pref all flags");
        offer(1, 0, 0, 0, 8'h12, 4'h5, 4, "R2 pref no mshr");
        offer(0, 1, 1, 1, 8'h21, 4'h6, 4, "R3 write hit");
        offer(0, 1, 0, 0, 8'h22, 4'h7, 4, "R3 write hit no mshr");
        offer(0, 0, 0, 1, 8'h31, 4'h9, 3, "R4 no mshr");
        offer(0, 0, 1, 1, 8'h41, 4'hA, 1, "R5 ifetch");
        offer(0, 0, 1, 0, 8'h51, 4'hB, 2, "R6 data");
    endtask

    task automatic t_idle();
        @(negedge clk);
        check(outcome() == 0, "R11 idle", outcome(), 0);
    endtask

    // Full queues must not stall replies that need no queue.
    task automatic t_full_bypass();
        iq_full = 1'b1; dq_full = 1'b1;
        offer(1, 0, 1, 1, 8'h61, 4'h1, 4, "R7 full pref");
        offer(0, 1, 1, 0, 8'h62, 4'h2, 4, "R7 full wh");
        offer(0, 0, 0, 0, 8'h63, 4'h4, 3, "R7 full gperf");
        iq_full = 1'b0; dq_full = 1'b0;
    endtask

    task automatic t_stall(input bit f, input string req);
        if (f) iq_full = 1'b1; else dq_full = 1'b1;
        if (f) dq_full = 1'b0; else iq_full = 1'b0;
        rsp_vld = 1'b1; rsp_pref = 0; rsp_l1wh = 0; rsp_has_mshr = 1; rsp_ifetch = f;
        rsp_tag = 8'h70 + 8'(f); rsp_prog = 4'hF;
        #1;
        check(rsp_rdy === 1'b0, {req, " R7 rdy low"}, int'(rsp_rdy), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(outcome() == 0, {req, " R8 no pulse"}, outcome(), 0);
        end
        iq_full = 1'b0; dq_full = 1'b0;
        #1;
        check(rsp_rdy === 1'b1, {req, " R7 rdy high"}, int'(rsp_rdy), 1);
        @(negedge clk);
        rsp_vld = 1'b0;
        check(outcome() == (f ? 1 : 2), {req, " R8 delivered"}, outcome(), f ? 1 : 2);
        check(fwd_prog == 0, {req, " R9 prog"}, int'(fwd_prog), 0);
        @(negedge clk);
        check(outcome() == 0, {req, " R10 once"}, outcome(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_classes();
        t_idle();
        t_full_bypass();
        t_stall(1'b1, "iq");
        t_stall(1'b0, "dq");
        // Other queue full must not block: data reply with only iq full.
        iq_full = 1'b1;
        offer(0, 0, 1, 0, 8'h81, 4'h8, 2, "R7 other queue full");
        iq_full = 1'b0;
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule